// File: doc/BRIEF.md
# Serial EEPROM Word Reader

This block fetches 16-bit words from a three-wire serial EEPROM, one that has a select line, a shift clock, a data line into the memory and a data line out of it. The host pulses `start` with an even byte address and an even, non-zero byte count. The block halves the address to get the first word address. For every word it runs a complete transaction: it selects the device, sends the read opcode and the 6-bit word address, clocks 16 data bits in, and deselects the device. Each word is passed back as two bytes on consecutive cycles, the low byte first, each marked by `byte_valid`.

Every pin phase lasts one timing step. A step is `TICKS_PER_STEP` system clocks long. The default of 250 clocks gives 1 us at 250 MHz. A request with an odd address, an odd count or a zero count is refused: it sets `err` and performs no access. `start` has no effect while a transfer is in progress.

Top module: `eeprom_word_reader`

## Requirements
- R1: A `start` seen while idle is refused when `start_addr[0]` is 1, when `byte_count[0]` is 1, or when `byte_count` is 0. In that case `err` is 1 from the next cycle on, `busy` stays 0 and `ee_cs` stays 0. The next accepted start clears `err`.
- R2: Each word begins with four steps. In the first, `ee_cs` and `ee_sk` are both 0. In the second, `ee_cs` is 1 and `ee_sk` is 0. In the third, both are 1. In the fourth, `ee_cs` is 1 and `ee_sk` is 0. `ee_sk` is never 1 while `ee_cs` is 0.
- R3: After the select, `ee_di` carries the read opcode 3'b110, MSB first. It then carries the word address `start_addr[6:1]` (plus the word offset), MSB first. Each bit uses three steps: clock low, clock high, clock low. `ee_di` holds steady across all three.
- R4: Sixteen data bits follow, MSB first. Each bit is a high step and then a low step. `ee_do` is sampled at the end of the high step. One word therefore takes 26 rising edges of `ee_sk`.
- R5: After the data bits `ee_cs` drops for one step. A request moves `byte_count/2` words. The word address goes up by one per word and wraps from 63 to 0.
- R6: Each word is delivered on `byte_out` as bits 7:0 and then bits 15:8, in two consecutive cycles with `byte_valid` high. `byte_valid` is never high for more than two cycles in a row.
- R7: `busy` is 1 from the cycle after an accepted start up to and including the cycle of the last byte, and 0 afterwards. A `start` while `busy` is 1 has no effect, even in the cycle of the last byte.
- R8: Every `ee_sk` high pulse lasts exactly `TICKS_PER_STEP` clocks. The first `byte_valid` comes 64·`TICKS_PER_STEP`+2 clock cycles after the edge that accepts `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request pulse, taken only while idle |
| start_addr | input | 7 | Byte start address, must be even |
| byte_count | input | 8 | Number of bytes to read, even and non-zero |
| busy | output | 1 | Transfer in progress |
| err | output | 1 | Last request was refused |
| byte_valid | output | 1 | `byte_out` holds a delivered byte |
| byte_out | output | 8 | Delivered byte, low half of each word first |
| ee_cs | output | 1 | EEPROM chip select |
| ee_sk | output | 1 | EEPROM serial clock |
| ee_di | output | 1 | Serial data into the EEPROM |
| ee_do | input | 1 | Serial data from the EEPROM |

## Verification
Two events can fall in the same cycle: delivery of the final high byte, and a new request on `start`. At that moment `busy` is still 1, so the request must be dropped. The bench raises `start` in exactly the cycle where it sees the last `byte_valid` of a transfer. It then checks that `busy`, `err` and `ee_cs` all stay at 0 for several steps. It then issues a fresh request one cycle later and checks that this one is taken normally. The same pattern is used mid-transfer, with an odd address that would set `err` if it were accepted.

// File: rtl/eerd_pkg.sv
package eerd_pkg;

    localparam int OP_BITS    = 3;
    localparam int WADDR_BITS = 6;
    localparam int WORD_BITS  = 16;
    localparam int CNT_BITS   = 8;
    localparam int CMD_BITS   = OP_BITS + WADDR_BITS;
    localparam int IDX_W      = 5;

    localparam logic [OP_BITS-1:0] READ_OP = 3'b110;

    typedef enum logic [2:0] {
        F_IDLE, F_SEL, F_CMD, F_DAT, F_END
    } frame_st_e;

    typedef enum logic [2:0] {
        C_IDLE, C_LAUNCH, C_WAIT, C_LO, C_HI
    } ctl_st_e;

    typedef struct packed {
        logic [WADDR_BITS-1:0] waddr;
        logic [CNT_BITS-2:0]   words_left;
    } xfer_t;

    function automatic logic bad_request(input logic addr_lsb,
                                         input logic [CNT_BITS-1:0] cnt);
        return addr_lsb | cnt[0] | (cnt == '0);
    endfunction

endpackage

// File: rtl/eerd_step_timer.sv
module eerd_step_timer #(
    parameter int TICKS = 250
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic step_end
);
    localparam int CW = (TICKS > 1) ? $clog2(TICKS) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICKS - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !run || cnt == LAST) cnt <= '0;
        else                            cnt <= cnt + 1'b1;
    end

    assign step_end = run && (cnt == LAST);

    generate
        if (TICKS > 1) begin : g_multi
            // R8
            step_gap_chk: assert property (@(posedge clk) disable iff (rst)
                step_end |=> !step_end);
        end
    endgenerate
endmodule

// File: rtl/eerd_frame_seq.sv
module eerd_frame_seq
    import eerd_pkg::*;
#(
    parameter int TICKS = 250
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  go,
    input  logic [WADDR_BITS-1:0] waddr,
    input  logic                  ee_do,
    output logic                  ee_cs,
    output logic                  ee_sk,
    output logic                  ee_di,
    output logic                  done,
    output logic [WORD_BITS-1:0]  word
);
    localparam logic [IDX_W-1:0] CMD_LAST  = IDX_W'(CMD_BITS - 1);
    localparam logic [IDX_W-1:0] WORD_LAST = IDX_W'(WORD_BITS - 1);

    frame_st_e           st;
    logic [1:0]          ph;
    logic [IDX_W-1:0]    bc;
    logic [CMD_BITS-1:0] sr;
    logic                step_end;
    logic                running;

    assign running = (st != F_IDLE);

    eerd_step_timer #(.TICKS(TICKS)) u_tmr (
        .clk      (clk),
        .rst      (rst),
        .run      (running),
        .step_end (step_end)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st   <= F_IDLE;
            ph   <= '0;
            bc   <= '0;
            sr   <= '0;
            word <= '0;
        end else begin
            case (st)
                F_IDLE: if (go) begin
                    st <= F_SEL;
                    ph <= '0;
                    sr <= {READ_OP, waddr};
                end
                F_SEL: if (step_end) begin
                    if (ph == 2'd3) begin
                        st <= F_CMD;
                        ph <= '0;
                        bc <= '0;
                    end else begin
                        ph <= ph + 2'd1;
                    end
                end
                F_CMD: if (step_end) begin
                    if (ph == 2'd2) begin
                        ph <= '0;
                        sr <= sr << 1;
                        if (bc == CMD_LAST) begin
                            st <= F_DAT;
                            bc <= '0;
                        end else begin
                            bc <= bc + 1'b1;
                        end
                    end else begin
                        ph <= ph + 2'd1;
                    end
                end
                F_DAT: if (step_end) begin
                    if (ph == 2'd0) begin
                        word <= {word[WORD_BITS-2:0], ee_do};
                        ph   <= 2'd1;
                    end else begin
                        ph <= '0;
                        if (bc == WORD_LAST) st <= F_END;
                        else                 bc <= bc + 1'b1;
                    end
                end
                F_END: if (step_end) st <= F_IDLE;
                default: st <= F_IDLE;
            endcase
        end
    end

    always_comb begin
        ee_cs = 1'b0;
        ee_sk = 1'b0;
        ee_di = 1'b0;
        case (st)
            F_SEL: begin
                ee_cs = (ph != 2'd0);
                ee_sk = (ph == 2'd2);
            end
            F_CMD: begin
                ee_cs = 1'b1;
                ee_sk = (ph == 2'd1);
                ee_di = sr[CMD_BITS-1];
            end
            F_DAT: begin
                ee_cs = 1'b1;
                ee_sk = (ph == 2'd0);
            end
            default: ;
        endcase
    end

    assign done = (st == F_END) && step_end;

    // R2
    sk_needs_cs_chk: assert property (@(posedge clk) disable iff (rst)
        ee_sk |-> ee_cs);

    // R3
    di_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st == F_CMD && ph != 2'd0) |-> $stable(ee_di));

    // R5
    deselect_after_word_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> !ee_cs);
endmodule

// File: rtl/eeprom_word_reader.sv
module eeprom_word_reader
    import eerd_pkg::*;
#(
    parameter int TICKS_PER_STEP = 250
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  start,
    input  logic [WADDR_BITS:0]   start_addr,
    input  logic [CNT_BITS-1:0]   byte_count,
    output logic                  busy,
    output logic                  err,
    output logic                  byte_valid,
    output logic [7:0]            byte_out,
    output logic                  ee_cs,
    output logic                  ee_sk,
    output logic                  ee_di,
    input  logic                  ee_do
);
    localparam logic [CNT_BITS-2:0] ONE_LEFT = 1;

    ctl_st_e              st;
    xfer_t                xf;
    logic                 go;
    logic                 fdone;
    logic [WORD_BITS-1:0] fword;

    assign go = (st == C_LAUNCH);

    eerd_frame_seq #(.TICKS(TICKS_PER_STEP)) u_frame (
        .clk   (clk),
        .rst   (rst),
        .go    (go),
        .waddr (xf.waddr),
        .ee_do (ee_do),
        .ee_cs (ee_cs),
        .ee_sk (ee_sk),
        .ee_di (ee_di),
        .done  (fdone),
        .word  (fword)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st  <= C_IDLE;
            err <= 1'b0;
            xf  <= '0;
        end else begin
            case (st)
                C_IDLE: if (start) begin
                    if (bad_request(start_addr[0], byte_count)) begin
                        err <= 1'b1;
                    end else begin
                        err           <= 1'b0;
                        xf.waddr      <= start_addr[WADDR_BITS:1];
                        xf.words_left <= byte_count[CNT_BITS-1:1];
                        st            <= C_LAUNCH;
                    end
                end
                C_LAUNCH: st <= C_WAIT;
                C_WAIT:   if (fdone) st <= C_LO;
                C_LO:     st <= C_HI;
                C_HI: begin
                    if (xf.words_left == ONE_LEFT) begin
                        st <= C_IDLE;
                    end else begin
                        xf.words_left <= xf.words_left - 1'b1;
                        xf.waddr      <= xf.waddr + 1'b1;
                        st            <= C_LAUNCH;
                    end
                end
                default: st <= C_IDLE;
            endcase
        end
    end

    assign busy       = (st != C_IDLE);
    assign byte_valid = (st == C_LO) || (st == C_HI);
    assign byte_out   = (st == C_HI) ? fword[15:8] : fword[7:0];

    // R7
    valid_needs_busy_chk: assert property (@(posedge clk) disable iff (rst)
        byte_valid |-> busy);

    // R7
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (start && busy) |=> $stable(err));

    // R1
    bad_start_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && (start_addr[0] || byte_count[0] || byte_count == '0))
            |=> (err && !busy));

    // R6
    hi_follows_lo_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(byte_valid) |=> byte_valid);

    // R6
    pair_ends_chk: assert property (@(posedge clk) disable iff (rst)
        (byte_valid && $past(byte_valid)) |=> !byte_valid);
endmodule

// File: tb/eeprom_word_reader_test.sv
module eeprom_word_reader_test;
    localparam int T = 3;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic [6:0] start_addr = '0;
    logic [7:0] byte_count = '0;
    logic       busy, err, byte_valid, ee_cs, ee_sk, ee_di;
    logic [7:0] byte_out;
    logic       ee_do = 1'b0;

    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    eeprom_word_reader #(.TICKS_PER_STEP(T)) uut (
        .clk(clk), .rst(rst), .start(start), .start_addr(start_addr),
        .byte_count(byte_count), .busy(busy), .err(err),
        .byte_valid(byte_valid), .byte_out(byte_out),
        .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di), .ee_do(ee_do)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [15:0] rom_word(input logic [5:0] w);
        return (16'(w) * 16'h0F1D) ^ 16'h5AC3;
    endfunction

    // memory model
    int          sk_edges = 0;
    logic [8:0]  cap = '0;
    logic [15:0] dword = '0;
    logic [5:0]  exp_waddr = '0;

    always @(posedge ee_cs) begin
        sk_edges = 0;
        cap = '0;
    end

    always @(posedge ee_sk) begin
        sk_edges = sk_edges + 1;
        if (sk_edges >= 2 && sk_edges <= 10) cap = {cap[7:0], ee_di};
        if (sk_edges == 10) begin
            chk(cap[8:6] == 3'b110, "R3 opcode", int'(cap[8:6]), 6);
            chk(cap[5:0] == exp_waddr, "R5 word address", int'(cap[5:0]), int'(exp_waddr));
            dword = rom_word(cap[5:0]);
            exp_waddr = exp_waddr + 6'd1;
        end
        if (sk_edges >= 11 && sk_edges <= 26) ee_do = dword[26 - sk_edges];
    end

    always @(negedge ee_cs) begin
        chk(sk_edges == 26, "R4 clock edges per word", sk_edges, 26);
    end

    // pulse width and byte monitors
    int         hi_run = 0;
    logic [7:0] exp_b [0:255];
    int         exp_n = 0;
    int         bidx = 0;

    always @(negedge clk) begin
        if (ee_sk) hi_run++;
        else if (hi_run > 0) begin
            chk(hi_run == T, "R8 sk high width", hi_run, T);
            hi_run = 0;
        end
        if (byte_valid && !rst) begin
            if (bidx < exp_n)
                chk(byte_out == exp_b[bidx], "R6 byte value", int'(byte_out), int'(exp_b[bidx]));
            else
                chk(1'b0, "R5 extra byte", bidx, exp_n);
            bidx++;
        end
    end

    // transfer with optional start injection
    // inj: 0 none, 1 odd start mid-run, 2 start in last-byte cycle
    task automatic xfer(input int addr, input int cnt, input int inj, input bit check_lat);
        int k, first_k, last_k, seen;
        for (int i = 0; i < cnt / 2; i++) begin
            logic [15:0] w;
            w = rom_word(6'((addr / 2 + i) % 64));
            exp_b[2*i]   = w[7:0];
            exp_b[2*i+1] = w[15:8];
        end
        exp_n = cnt;
        bidx = 0;
        exp_waddr = 6'(addr / 2);
        @(negedge clk);
        start = 1'b1; start_addr = 7'(addr); byte_count = 8'(cnt);
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        k = 1; first_k = -1; last_k = -1; seen = 0;
        chk(busy == 1'b1, "R7 busy after start", int'(busy), 1);
        chk(err == 1'b0, "R1 err cleared", int'(err), 0);
        while (busy && k < 40000) begin
            if (byte_valid) begin
                if (first_k < 0) first_k = k;
                last_k = k;
                seen++;
            end
            if (inj == 1 && k == 50) begin
                start = 1'b1; start_addr = 7'd5; byte_count = 8'd3;
            end else if (inj == 2 && byte_valid && seen == cnt) begin
                start = 1'b1; start_addr = 7'd10; byte_count = 8'd2;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            k++;
        end
        start = 1'b0;
        chk(busy == 1'b0, "R7 transfer ends", int'(busy), 0);
        chk(last_k + 1 == k, "R7 busy drops after last byte", k, last_k + 1);
        chk(bidx == cnt, "R5 byte total", bidx, cnt);
        chk(err == 1'b0, "R7 err untouched", int'(err), 0);
        if (check_lat)
            chk(first_k == 64 * T + 2, "R8 first byte latency", first_k, 64 * T + 2);
    endtask

    task automatic quiet_window(input string req);
        int cs_hi = 0;
        for (int i = 0; i < 6 * T; i++) begin
            @(negedge clk);
            if (ee_cs || busy) cs_hi++;
        end
        chk(cs_hi == 0, req, cs_hi, 0);
    endtask

    task automatic bad_start(input int addr, input int cnt);
        @(negedge clk);
        start = 1'b1; start_addr = 7'(addr); byte_count = 8'(cnt);
        @(negedge clk);
        start = 1'b0;
        chk(err == 1'b1, "R1 err set", int'(err), 1);
        chk(busy == 1'b0, "R1 stays idle", int'(busy), 0);
        quiet_window("R1 no access");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got 1 expected 0");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(busy == 1'b0, "R7 reset busy", int'(busy), 0);
        chk(err == 1'b0, "R1 reset err", int'(err), 0);
        chk(ee_cs == 1'b0 && ee_sk == 1'b0, "R2 reset pins", int'({ee_cs, ee_sk}), 0);
        chk(byte_valid == 1'b0, "R6 reset valid", int'(byte_valid), 0);

        // R1: refused requests
        bad_start(3, 2);
        bad_start(4, 5);
        bad_start(8, 0);

        // R8 / R2 / R3: single word at every word address
        for (int w = 0; w < 64; w++) xfer(2 * w, 2, 0, 1'b1);

        // R5: whole device in one request
        xfer(0, 128, 0, 1'b0);
        // R5: wrap from 63 to 0
        xfer(124, 8, 0, 1'b0);
        // R7: odd request while busy is ignored
        xfer(20, 6, 1, 1'b0);
        // R7: start in the cycle of the last byte is ignored
        xfer(40, 4, 2, 1'b0);
        quiet_window("R7 start at last byte ignored");
        // fresh request afterwards works
        xfer(62, 4, 0, 1'b1);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule